// File: doc/BRIEF.md
# Toggle-Acknowledge Global Error Register

This block records fatal conditions of a larger unit in a status word where each condition is signalled by flipping a bit rather than by setting it. Next to it sits an acknowledge word that the host owns. A condition counts as pending while its bit differs between the two words. To retire everything it has seen, the host reads the status word and writes that same value into the acknowledge word. No write-one-to-clear path is involved, so a condition that arrives while the host is handling the previous ones is never wiped out.

An interrupt control word selects which interrupts may fire. Bit 0 gates the error interrupt. Bit 2 is kept for the event-queue interrupt, which is driven elsewhere. Every value written to the control word appears, one cycle later, in a read-only confirmation word at the next 32-bit address. Software therefore writes the control word and then polls the confirmation word until it matches. The usual sequence is to write zero, wait for the match, and then write the enable bits. The sources of the conditions lie outside this block; each one arrives here as a single-cycle pulse on its own input line.

Top module: `gerr_unit`

## Requirements
- R1: After reset, all four words read as zero and `irq` is low.
- R2: A pulse on `errIn[b]` while bit b is not pending flips status bit b; the bit is then pending. Status reads at byte offset 0x0 and acknowledge at 0x4. Bit assignments: 0 command-queue fault, 1 event-queue write abort, 2 page-request-queue write abort, 3 command message-write abort, 4 event message-write abort, 5 page-request message-write abort, 6 generic message-write abort, 7 spare.
- R3: A pulse on a bit that is already pending leaves the status word unchanged.
- R4: Writing the status value into the acknowledge word clears every pending bit and leaves the status word untouched.
- R5: If a pulse arrives in the same cycle as an acknowledge write, it is judged against the newly written acknowledge value, so the bit is still pending afterwards.
- R6: The control word at 0x8 holds the written value, and the new value reads back from the next cycle on.
- R7: The confirmation word at 0xC reads the old control value in the cycle right after a control write and the new value one cycle later.
- R8: `irq` is high exactly when control bit 0 is set and at least one pending bit falls inside mask 0x7F. Bit 7 and control bit 2 have no effect on `irq`.
- R9: Writes to 0x0, to 0xC and to any other unmapped or misaligned address change no register.
- R10: Reading an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| errIn | input | NUM_ERR | One-cycle error pulses, one per condition |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | ADDR_W | Host write byte address |
| wrData | input | DATA_W | Host write data |
| rdAddr | input | ADDR_W | Host read byte address |
| rdData | output | DATA_W | Read data, combinational from rdAddr |
| irq | output | 1 | Error interrupt level |

## Verification
The hardest case to reach from the ports is a new pulse on a bit that is pending and whose status value was flipped back to zero, arriving in the very cycle the host acknowledges that bit. The stimulus first sets the bit, clears it, and raises it again, so that status holds 0 while acknowledge holds 1. It then drives the pulse and the acknowledge write on the same clock edge and checks that the bit is still pending. The bench also separately checks the masked spare bit and the one-cycle lag of the confirmation word.

// File: rtl/gerr_pkg.sv
package gerr_pkg;
  // Byte offsets of the host-visible words; the confirmation word must sit
  // one word above the control word.
  localparam int OFF_STATUS   = 0;
  localparam int OFF_ACK      = 4;
  localparam int OFF_CTRL     = 8;
  localparam int OFF_CTRL_ACK = OFF_CTRL + 4;

  // Control bit that gates the error interrupt.
  localparam int IRQ_EN_BIT = 0;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic ackWr;
    logic ctrlWr;
    logic selStatus;
    logic selAck;
    logic selCtrl;
    logic selCtrlAck;
  } strobe_t;
endpackage

// File: rtl/gerr_decode.sv
module gerr_decode
  import gerr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_ACK      = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CTRL_ACK = ADDR_W'(OFF_CTRL_ACK);

  // Only the two host-owned words accept writes; all else is dropped.
  always_comb begin
    stb.ackWr      = wrEn && (wrAddr == A_ACK);
    stb.ctrlWr     = wrEn && (wrAddr == A_CTRL);
    stb.selStatus  = (rdAddr == A_STATUS);
    stb.selAck     = (rdAddr == A_ACK);
    stb.selCtrl    = (rdAddr == A_CTRL);
    stb.selCtrlAck = (rdAddr == A_CTRL_ACK);
  end
endmodule

// File: rtl/gerr_regs.sv
module gerr_regs
  import gerr_pkg::*;
#(
  parameter int                   DATA_W   = 32,
  parameter int                   NUM_ERR  = 8,
  parameter logic [NUM_ERR-1:0]   IRQ_MASK = 8'h7F
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_ERR-1:0] errIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic [NUM_ERR-1:0] errState,
  output logic [NUM_ERR-1:0] errAck,
  output logic [DATA_W-1:0]  ctrlReg,
  output logic [DATA_W-1:0]  ctrlAck
);
  localparam int PAD_W = DATA_W - NUM_ERR;

  // One toggle cell per condition. The pending test uses the acknowledge
  // value that is being written this cycle, so a pulse that meets an
  // acknowledge write is kept.
  for (genvar b = 0; b < NUM_ERR; b++) begin : g_cell
    logic ackNextBit;
    logic pendNext;
    assign ackNextBit = stb.ackWr ? wrData[b] : errAck[b];
    assign pendNext   = errState[b] ^ ackNextBit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        errState[b] <= 1'b0;
        errAck[b]   <= 1'b0;
      end else begin
        if (errIn[b] && !pendNext) errState[b] <= ~errState[b];
        errAck[b] <= ackNextBit;
      end
    end
  end

  // Control word and its one-cycle-late confirmation copy.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      ctrlAck <= '0;
    end else begin
      if (stb.ctrlWr) ctrlReg <= wrData;
      ctrlAck <= ctrlReg;
    end
  end

  logic [NUM_ERR-1:0] pending;
  assign pending = errState ^ errAck;
  assign irq     = ctrlReg[IRQ_EN_BIT] && |(pending & IRQ_MASK);

  always_comb begin
    rdData = '0;
    unique case (1'b1)
      stb.selStatus:  rdData = {{PAD_W{1'b0}}, errState};
      stb.selAck:     rdData = {{PAD_W{1'b0}}, errAck};
      stb.selCtrl:    rdData = ctrlReg;
      stb.selCtrlAck: rdData = ctrlAck;
      default:        rdData = '0;
    endcase
  end
endmodule

// File: rtl/gerr_unit.sv
module gerr_unit
  import gerr_pkg::*;
#(
  parameter int                 ADDR_W   = 4,
  parameter int                 DATA_W   = 32,
  parameter int                 NUM_ERR  = 8,
  parameter logic [NUM_ERR-1:0] IRQ_MASK = 8'h7F
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_ERR-1:0] errIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  strobe_t            stb;
  logic [NUM_ERR-1:0] errState;
  logic [NUM_ERR-1:0] errAck;
  logic [DATA_W-1:0]  ctrlReg;
  logic [DATA_W-1:0]  ctrlAck;

  gerr_decode #(.ADDR_W(ADDR_W)) i_decode (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .stb    (stb)
  );

  gerr_regs #(
    .DATA_W   (DATA_W),
    .NUM_ERR  (NUM_ERR),
    .IRQ_MASK (IRQ_MASK)
  ) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .errIn    (errIn),
    .rdData   (rdData),
    .irq      (irq),
    .errState (errState),
    .errAck   (errAck),
    .ctrlReg  (ctrlReg),
    .ctrlAck  (ctrlAck)
  );
endmodule

// File: rtl/gerr_unit_chk.sv
module gerr_unit_chk
  import gerr_pkg::*;
#(
  parameter int                 ADDR_W   = 4,
  parameter int                 DATA_W   = 32,
  parameter int                 NUM_ERR  = 8,
  parameter logic [NUM_ERR-1:0] IRQ_MASK = 8'h7F
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_ERR-1:0] errIn,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic               irq,
  input logic [NUM_ERR-1:0] errState,
  input logic [NUM_ERR-1:0] errAck,
  input logic [DATA_W-1:0]  ctrlReg,
  input logic [DATA_W-1:0]  ctrlAck
);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  // Any pulsed condition is pending one cycle later (R2, R5).
  p_pulse_pending_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|errIn) |=> (((errState ^ errAck) & $past(errIn)) == $past(errIn)));

  // Without pulses the status word holds (R3, R4).
  p_status_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (errIn == '0) |=> $stable(errState));

  // Acknowledge write lands (R4).
  p_ack_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_ACK) |=> (errAck == $past(wrData[NUM_ERR-1:0])));

  // Control write lands (R6).
  p_ctrl_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_CTRL) |=> (ctrlReg == $past(wrData)));

  // Confirmation follows two edges after the write (R7).
  p_ctrl_mirror_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_CTRL) |=> ##1 (ctrlAck == $past(wrData, 2)));

  // No interrupt while disabled or nothing is pending (R8).
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[IRQ_EN_BIT] |-> !irq);
  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (((errState ^ errAck) & IRQ_MASK) == '0) |-> !irq);
endmodule

bind gerr_unit gerr_unit_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_ERR  (NUM_ERR),
  .IRQ_MASK (IRQ_MASK)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .errIn    (errIn),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .irq      (irq),
  .errState (errState),
  .errAck   (errAck),
  .ctrlReg  (ctrlReg),
  .ctrlAck  (ctrlAck)
);

// File: tb/test_gerr_unit.sv
module test_gerr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int NUM_ERR = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_ERR-1:0] errIn = '0;
  logic               wrEn = 1'b0;
  logic [ADDR_W-1:0]  wrAddr = '0;
  logic [DATA_W-1:0]  wrData = '0;
  logic [ADDR_W-1:0]  rdAddr = '0;
  logic [DATA_W-1:0]  rdData;
  logic               irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gerr_unit i_gerr_unit (
    .clk(clk), .rstN(rstN), .errIn(errIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic readWord(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic checkWord(input string req, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] d;
    readWord(a, d);
    check(req, $sformatf("word 0x%0h", a), d, exp);
  endtask

  // Drive at negedge, commit at posedge, return at the following negedge.
  task automatic cycle(input logic [NUM_ERR-1:0] e, input logic we,
                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    errIn = e; wrEn = we; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    errIn = '0; wrEn = 1'b0;
  endtask

  task automatic t_reset;
    checkWord("R1", 4'h0, 0);
    checkWord("R1", 4'h4, 0);
    checkWord("R1", 4'h8, 0);
    checkWord("R1", 4'hC, 0);
    check("R1", "irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl_ack;
    cycle('0, 1'b1, 4'h8, 32'h0);
    checkWord("R6", 4'h8, 0);
    cycle('0, 1'b1, 4'h8, 32'h5);
    checkWord("R6", 4'h8, 32'h5);
    checkWord("R7", 4'hC, 32'h0);
    cycle('0, 1'b0, 4'h0, 0);
    checkWord("R7", 4'hC, 32'h5);
    cycle('0, 1'b1, 4'h8, 32'h1);
    cycle('0, 1'b0, 4'h0, 0);
    checkWord("R7", 4'hC, 32'h1);
  endtask

  task automatic t_toggle;
    cycle(8'h02, 1'b0, 4'h0, 0);
    checkWord("R2", 4'h0, 32'h02);
    checkWord("R2", 4'h4, 32'h00);
    check("R8", "irq pending", {31'b0, irq}, 1);
  endtask

  task automatic t_repeat;
    cycle(8'h02, 1'b0, 4'h0, 0);
    checkWord("R3", 4'h0, 32'h02);
    cycle(8'h08, 1'b0, 4'h0, 0);
    checkWord("R2", 4'h0, 32'h0A);
  endtask

  task automatic t_clear;
    logic [DATA_W-1:0] s;
    readWord(4'h0, s);
    cycle('0, 1'b1, 4'h4, s);
    checkWord("R4", 4'h0, 32'h0A);
    checkWord("R4", 4'h4, 32'h0A);
    check("R4", "irq after ack", {31'b0, irq}, 0);
  endtask

  task automatic t_coincide;
    cycle(8'h02, 1'b0, 4'h0, 0);
    checkWord("R2", 4'h0, 32'h08);
    cycle(8'h02, 1'b1, 4'h4, 32'h08);
    checkWord("R5", 4'h0, 32'h0A);
    checkWord("R5", 4'h4, 32'h08);
    check("R5", "irq kept", {31'b0, irq}, 1);
    cycle('0, 1'b1, 4'h4, 32'h0A);
    check("R4", "irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_mask;
    cycle(8'h80, 1'b0, 4'h0, 0);
    checkWord("R2", 4'h0, 32'h8A);
    check("R8", "spare bit masked", {31'b0, irq}, 0);
    cycle('0, 1'b1, 4'h8, 32'h4);
    cycle(8'h01, 1'b0, 4'h0, 0);
    checkWord("R2", 4'h0, 32'h8B);
    check("R8", "event enable only", {31'b0, irq}, 0);
    cycle('0, 1'b1, 4'h8, 32'h1);
    check("R8", "enabled", {31'b0, irq}, 1);
    cycle('0, 1'b1, 4'h4, 32'h8B);
    check("R8", "cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_ignored;
    cycle('0, 1'b1, 4'h0, 32'hFF);
    checkWord("R9", 4'h0, 32'h8B);
    cycle('0, 1'b1, 4'hC, 32'h0);
    cycle('0, 1'b0, 4'h0, 0);
    checkWord("R9", 4'hC, 32'h1);
    cycle('0, 1'b1, 4'h2, 32'h0);
    cycle('0, 1'b1, 4'hA, 32'h0);
    checkWord("R9", 4'h4, 32'h8B);
    checkWord("R9", 4'h8, 32'h1);
    checkWord("R10", 4'h6, 32'h0);
    checkWord("R10", 4'hD, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_ctrl_ack;
    t_toggle;
    t_repeat;
    t_clear;
    t_coincide;
    t_mask;
    t_ignored;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule